// File: doc/BRIEF.md
# Event counter bank

A bank of event counters for performance monitoring, reached through a simple 32-bit register port. Each counter watches one line of a wide vector of per-cycle event pulses. The line is chosen by an 8-bit event code that software writes. Software turns counters on one at a time and starts or stops the whole bank with a single global enable. Every counter is 64 bits wide and is read and written as two 32-bit words. A build parameter narrows the implemented width to 48 bits.

When a counter wraps from all-ones to zero, it sets its own interrupt status bit. The interrupt output is raised while any status bit is set and its mask bit is clear. Software clears a status bit by writing a one to the matching bit of a separate clear register. Register writes take effect on the next clock edge. Reads are combinational from the address.

Top module: `ecb_top`

## Requirements
- R1: After reset, all counters, the global enable, the per-counter enables, the event codes and the status bits read as zero. The mask register at 0x0800 reads with all counter bits set (0xFF). The irq output is low.
- R2: The global enable is bit 16 of the control register at 0x0408. While it is clear, no counter changes except through a software write.
- R3: Counter i advances only while bit i of the enable register at 0x1C00 and the global enable are both set.
- R4: The event code of counter i is stored in the register at 0x1D00 + (i/4)*4, bits [8*(i%4)+7 : 8*(i%4)], and reads back from there. Counter i adds one on each clock edge at which event_pulse[code] is high and the counter is enabled.
- R5: The low word of counter i is at 0x1E00 + 8*i and the high word is at 0x1E00 + 8*i + 4. Both words can be written and read back.
- R6: With CTR_W = 48, a high-word read returns counter bits [47:32] in bits [15:0] and zero in bits [31:16]. Bits [31:16] of a high-word write are discarded.
- R7: A software write to a counter word in the same cycle as an increment wins. The counter then holds the written word and the other word unchanged, with no increment.
- R8: An increment that takes counter i from all-ones to zero at its implemented width sets status bit i, which is read at 0x0808.
- R9: Writing a 1 to bit i of the clear register at 0x080C clears status bit i. Bits written as 0 leave their status bits unchanged.
- R10: Bit i of the mask register at 0x0800 masks counter i when 1. The irq output is high exactly when some status bit is set and its mask bit is 0.
- R11: The version register at 0x1CF0 returns the implemented counter width in bits [7:0] and zero elsewhere. An address that maps to no register reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | AW (16) | Byte address of the register, word aligned |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data for reg_addr, combinational |
| event_pulse | input | 2**CODE_W (256) | Per-cycle event pulses indexed by event code |
| irq | output | 1 | OR of unmasked status bits |

## Verification
The bench builds the block with CTR_W = 48 and keeps eight counters and 8-bit codes. The narrow width makes the discarded and read-as-zero high bits observable. It also lets a counter be preloaded to all-ones with two writes and then wrapped with a single event pulse. The bench sweeps every counter through every byte lane of the code registers, through both words of its address pair and through a wrap. It drives a different number of event pulses into each counter so that each one ends at a distinct count.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  // register byte offsets
  localparam int OFS_CTRL = 'h0408;
  localparam int OFS_MASK = 'h0800;
  localparam int OFS_STAT = 'h0808;
  localparam int OFS_CLR  = 'h080C;
  localparam int OFS_CEN  = 'h1C00;
  localparam int OFS_VER  = 'h1CF0;
  localparam int OFS_EVT  = 'h1D00;
  localparam int OFS_CNT  = 'h1E00;
  localparam int GEN_BIT  = 16;
  localparam int LANE_W   = 8;
endpackage

// File: rtl/ecb_counter.sv
module ecb_counter #(
  parameter int CTR_W = 64,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [DW-1:0]    wdata,
  output logic [CTR_W-1:0] cnt,
  output logic             wrap
);
  localparam int HI_W = CTR_W - DW;

  logic [CTR_W-1:0] cnt_q, cnt_d;
  logic             ld;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    ld    = wr_lo | wr_hi | inc;
    if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_d[DW-1:0]     = wdata;
      if (wr_hi) cnt_d[CTR_W-1:DW] = wdata[HI_W-1:0];
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
      wrap  = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (ld) cnt_q <= cnt_d;
  end

  generate
    if (HI_W < DW) begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^wdata[DW-1:HI_W];
    end
  endgenerate

  assign cnt = cnt_q;
endmodule

// File: rtl/ecb_irq.sv
module ecb_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wrap,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] mask,
  output logic [N-1:0] stat,
  output logic         irq
);
  logic [N-1:0] stat_q, stat_d;
  logic         ld;

  always_comb begin
    ld     = clr_wr | (|wrap);
    stat_d = stat_q;
    if (clr_wr) stat_d = stat_d & ~clr_bits;
    stat_d = stat_d | wrap;   // a wrap wins over a clear in the same cycle
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  stat_q <= '0;
    else if (ld) stat_q <= stat_d;
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & ~mask);
endmodule

// File: rtl/ecb_rdmux.sv
module ecb_rdmux import ecb_pkg::*; #(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 64,
  parameter int AW      = 16,
  parameter int DW      = 32
) (
  input  logic [AW-1:0]              addr,
  input  logic                       gen,
  input  logic [NUM_CTR-1:0]         cen,
  input  logic [NUM_CTR-1:0]         mask,
  input  logic [NUM_CTR-1:0]         stat,
  input  logic [NUM_CTR*LANE_W-1:0]  codes,
  input  logic [NUM_CTR*CTR_W-1:0]   cnts,
  output logic [DW-1:0]              rdata
);
  localparam int LANES   = DW / LANE_W;
  localparam int NUM_SEL = (NUM_CTR + LANES - 1) / LANES;
  localparam int HI_W    = CTR_W - DW;

  always_comb begin
    rdata = '0;
    if (addr == AW'(OFS_CTRL)) rdata[GEN_BIT]     = gen;
    if (addr == AW'(OFS_MASK)) rdata[NUM_CTR-1:0] = mask;
    if (addr == AW'(OFS_STAT)) rdata[NUM_CTR-1:0] = stat;
    if (addr == AW'(OFS_CEN))  rdata[NUM_CTR-1:0] = cen;
    if (addr == AW'(OFS_VER))  rdata[7:0]         = 8'(CTR_W);
    for (int j = 0; j < NUM_SEL; j++) begin
      if (addr == AW'(OFS_EVT + 4*j)) begin
        for (int l = 0; l < LANES; l++) begin
          if (j*LANES + l < NUM_CTR)
            rdata[l*LANE_W +: LANE_W] = codes[(j*LANES+l)*LANE_W +: LANE_W];
        end
      end
    end
    for (int i = 0; i < NUM_CTR; i++) begin
      if (addr == AW'(OFS_CNT + 8*i))     rdata            = cnts[i*CTR_W +: DW];
      if (addr == AW'(OFS_CNT + 8*i + 4)) rdata[HI_W-1:0] = cnts[i*CTR_W+DW +: HI_W];
    end
  end
endmodule

// File: rtl/ecb_top.sv
module ecb_top import ecb_pkg::*; #(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 64,
  parameter int CODE_W  = 8,
  parameter int AW      = 16,
  parameter int DW      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  input  logic [(1<<CODE_W)-1:0] event_pulse,
  output logic                  irq
);
  localparam int LANES   = DW / LANE_W;
  localparam int NUM_SEL = (NUM_CTR + LANES - 1) / LANES;

  logic                             gen_q, gen_d;
  logic [NUM_CTR-1:0]               cen_q, cen_d;
  logic [NUM_CTR-1:0]               mask_q, mask_d;
  logic [NUM_CTR-1:0][LANE_W-1:0]   code_q, code_d;
  logic [NUM_CTR-1:0]               stat_q;
  logic [NUM_CTR-1:0]               wrap_v;
  logic [NUM_CTR*CTR_W-1:0]         cnt_flat;
  logic [NUM_CTR*LANE_W-1:0]        code_flat;
  logic                             clr_wr;

  // control register next state
  always_comb begin
    gen_d  = gen_q;
    cen_d  = cen_q;
    mask_d = mask_q;
    code_d = code_q;
    if (reg_addr == AW'(OFS_CTRL)) gen_d  = reg_wdata[GEN_BIT];
    if (reg_addr == AW'(OFS_CEN))  cen_d  = reg_wdata[NUM_CTR-1:0];
    if (reg_addr == AW'(OFS_MASK)) mask_d = reg_wdata[NUM_CTR-1:0];
    for (int j = 0; j < NUM_SEL; j++) begin
      if (reg_addr == AW'(OFS_EVT + 4*j)) begin
        for (int l = 0; l < LANES; l++) begin
          if (j*LANES + l < NUM_CTR)
            code_d[j*LANES+l] = reg_wdata[l*LANE_W +: LANE_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= 1'b0;
      cen_q  <= '0;
      mask_q <= '1;
      code_q <= '0;
    end else if (reg_wr) begin
      gen_q  <= gen_d;
      cen_q  <= cen_d;
      mask_q <= mask_d;
      code_q <= code_d;
    end
  end

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      logic             inc, wr_lo, wr_hi;
      logic [CTR_W-1:0] cnt;
      assign inc   = gen_q & cen_q[i] & event_pulse[code_q[i][CODE_W-1:0]];
      assign wr_lo = reg_wr && (reg_addr == AW'(OFS_CNT + 8*i));
      assign wr_hi = reg_wr && (reg_addr == AW'(OFS_CNT + 8*i + 4));
      ecb_counter #(.CTR_W(CTR_W), .DW(DW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (reg_wdata),
        .cnt   (cnt),
        .wrap  (wrap_v[i])
      );
      assign cnt_flat[i*CTR_W +: CTR_W]   = cnt;
      assign code_flat[i*LANE_W +: LANE_W] = code_q[i];
    end
    if (CODE_W < LANE_W) begin : g_code_pad
      logic unused_code;
      assign unused_code = ^code_flat;
    end
  endgenerate

  assign clr_wr = reg_wr && (reg_addr == AW'(OFS_CLR));

  ecb_irq #(.N(NUM_CTR)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap     (wrap_v),
    .clr_wr   (clr_wr),
    .clr_bits (reg_wdata[NUM_CTR-1:0]),
    .mask     (mask_q),
    .stat     (stat_q),
    .irq      (irq)
  );

  ecb_rdmux #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .AW(AW), .DW(DW)) u_rd (
    .addr  (reg_addr),
    .gen   (gen_q),
    .cen   (cen_q),
    .mask  (mask_q),
    .stat  (stat_q),
    .codes (code_flat),
    .cnts  (cnt_flat),
    .rdata (reg_rdata)
  );
endmodule

// File: rtl/ecb_chk.sv
module ecb_chk import ecb_pkg::*; #(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 64,
  parameter int AW      = 16,
  parameter int DW      = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic [AW-1:0]            reg_addr,
  input logic [DW-1:0]            reg_wdata,
  input logic [DW-1:0]            reg_rdata,
  input logic                     irq,
  input logic                     gen_q,
  input logic [NUM_CTR-1:0]       mask_q,
  input logic [NUM_CTR-1:0]       stat_q,
  input logic [NUM_CTR-1:0]       wrap_v,
  input logic [NUM_CTR*CTR_W-1:0] cnt_flat
);
  localparam int HI_W = CTR_W - DW;

  // R2
  gen_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_q && !reg_wr) |=> $stable(cnt_flat));

  // R7
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(OFS_CNT)) |=> (cnt_flat[DW-1:0] == $past(reg_wdata)));

  // R10
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);

  // R10
  irq_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|stat_q));

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_bit
      // R8
      wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_v[i] |=> stat_q[i]);
      // R9
      stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[i] && !(reg_wr && reg_addr == AW'(OFS_CLR) && reg_wdata[i])) |=> stat_q[i]);
    end
    if (HI_W < DW) begin : g_raz
      // R6
      hi_raz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= AW'(OFS_CNT) && reg_addr < AW'(OFS_CNT + 8*NUM_CTR) && reg_addr[2])
        |-> ((reg_rdata >> HI_W) == '0));
    end
  endgenerate
endmodule

bind ecb_top ecb_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .gen_q     (gen_q),
  .mask_q    (mask_q),
  .stat_q    (stat_q),
  .wrap_v    (wrap_v),
  .cnt_flat  (cnt_flat)
);

// File: tb/test_ecb_top.sv
`timescale 1ns/1ps
module test_ecb_top;
  localparam int N    = 8;
  localparam int CW   = 48;
  localparam int NEVT = 256;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            reg_wr;
  logic [15:0]     reg_addr;
  logic [31:0]     reg_wdata;
  logic [31:0]     reg_rdata;
  logic [NEVT-1:0] event_pulse;
  logic            irq;

  int checks = 0;
  int failures = 0;
  logic [7:0] code [N];

  always #2 clk = ~clk;

  ecb_top #(.NUM_CTR(N), .CTR_W(CW), .CODE_W(8), .AW(16), .DW(32)) i_ecb_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .event_pulse(event_pulse), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic rdchk(input string req, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse_all();
    @(negedge clk);
    for (int i = 0; i < N; i++) event_pulse[code[i]] = 1'b1;
    @(negedge clk);
    event_pulse = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; event_pulse = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdchk("R1 ctrl", 16'h0408, 32'h0);
    rdchk("R1 mask", 16'h0800, 32'hFF);
    rdchk("R1 stat", 16'h0808, 32'h0);
    rdchk("R1 cen",  16'h1C00, 32'h0);
    rdchk("R1 evt0", 16'h1D00, 32'h0);
    rdchk("R1 evt1", 16'h1D04, 32'h0);
    for (int i = 0; i < N; i++) begin
      rdchk("R1 cnt lo", 16'(16'h1E00 + 8*i), 32'h0);
      rdchk("R1 cnt hi", 16'(16'h1E04 + 8*i), 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R11 version and unmapped
    rdchk("R11 version", 16'h1CF0, 32'd48);
    rdchk("R11 unmapped", 16'h0400, 32'h0);
    rdchk("R11 unmapped", 16'h1E40, 32'h0);

    // R4 lane sweep
    for (int i = 0; i < N; i++) begin
      logic [15:0] a;
      logic [31:0] v;
      a = 16'(16'h1D00 + (i/4)*4);
      v = 32'(8'hA0 + i) << (8*(i%4));
      wr(a, v);
      rdchk("R4 lane", a, v);
    end
    for (int i = 0; i < N; i++) code[i] = 8'(17*i + 5);
    wr(16'h1D00, {code[3], code[2], code[1], code[0]});
    wr(16'h1D04, {code[7], code[6], code[5], code[4]});
    rdchk("R4 evt0", 16'h1D00, {code[3], code[2], code[1], code[0]});
    rdchk("R4 evt1", 16'h1D04, {code[7], code[6], code[5], code[4]});

    // R5 / R6 word access
    for (int i = 0; i < N; i++) begin
      logic [31:0] lo, hi;
      lo = 32'hA500_0000 | 32'(i*3 + 1);
      hi = 32'h5A5A_0000 | 32'(i << 8) | 32'(i);
      wr(16'(16'h1E00 + 8*i), lo);
      wr(16'(16'h1E04 + 8*i), hi);
      rdchk("R5 lo", 16'(16'h1E00 + 8*i), lo);
      rdchk("R6 hi", 16'(16'h1E04 + 8*i), hi & 32'h0000_FFFF);
    end
    for (int i = 0; i < N; i++) begin
      wr(16'(16'h1E00 + 8*i), 32'h0);
      wr(16'(16'h1E04 + 8*i), 32'h0);
    end

    // R4 counting: counter i sees i+1 pulses
    wr(16'h1C00, 32'hFF);
    wr(16'h0408, 32'h0001_0000);
    rdchk("R2 ctrl bit", 16'h0408, 32'h0001_0000);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      event_pulse = '0;
      for (int i = 0; i < N; i++) event_pulse[code[i]] = (k < i + 1);
    end
    @(negedge clk);
    event_pulse = '0;
    for (int i = 0; i < N; i++)
      rdchk("R4 count", 16'(16'h1E00 + 8*i), 32'(i + 1));

    // R2 global off
    wr(16'h0408, 32'h0);
    pulse_all();
    pulse_all();
    for (int i = 0; i < N; i++)
      rdchk("R2 hold", 16'(16'h1E00 + 8*i), 32'(i + 1));

    // R3 per-counter enable
    wr(16'h0408, 32'h0001_0000);
    wr(16'h1C00, 32'h0F);
    pulse_all();
    for (int i = 0; i < N; i++)
      rdchk("R3 gate", 16'(16'h1E00 + 8*i), 32'(i + 1 + ((i < 4) ? 1 : 0)));

    // R7 write beats increment on counter 1
    @(negedge clk);
    event_pulse[code[1]] = 1'b1;
    reg_wr = 1'b1; reg_addr = 16'h1E08; reg_wdata = 32'h0000_0100;
    @(negedge clk);
    reg_wr = 1'b0; event_pulse = '0;
    rdchk("R7 lo", 16'h1E08, 32'h0000_0100);
    rdchk("R7 hi", 16'h1E0C, 32'h0);

    // R8 wrap on every counter
    wr(16'h1C00, 32'hFF);
    for (int i = 0; i < N; i++) begin
      wr(16'(16'h1E00 + 8*i), 32'hFFFF_FFFF);
      wr(16'(16'h1E04 + 8*i), 32'hFFFF_FFFF);
    end
    rdchk("R8 pre", 16'h0808, 32'h0);
    pulse_all();
    rdchk("R8 stat", 16'h0808, 32'hFF);
    for (int i = 0; i < N; i++) begin
      rdchk("R8 lo zero", 16'(16'h1E00 + 8*i), 32'h0);
      rdchk("R8 hi zero", 16'(16'h1E04 + 8*i), 32'h0);
    end

    // R10 masking
    @(negedge clk);
    chk("R10 masked", {31'b0, irq}, 32'h0);
    wr(16'h0800, 32'hFB);
    rdchk("R10 mask rd", 16'h0800, 32'hFB);
    chk("R10 unmasked", {31'b0, irq}, 32'h1);

    // R9 clear
    wr(16'h080C, 32'h0);
    rdchk("R9 zero write", 16'h0808, 32'hFF);
    wr(16'h080C, 32'h04);
    rdchk("R9 clear bit2", 16'h0808, 32'hFB);
    @(negedge clk);
    chk("R10 cleared", {31'b0, irq}, 32'h0);
    wr(16'h080C, 32'hFB);
    rdchk("R9 clear rest", 16'h0808, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule